// File: doc/BRIEF.md
# Refresh-Aware Command Admission Filter

This block sits between command sources and the two command queues of a DRAM memory controller: one queue for strongly-ordered traffic and one for the rest. While a rank is being refreshed, commands aimed at that rank are held back at the queue entrance by dropping ready. The queues then do not fill with work that cannot be serviced yet, and commands for other ranks keep flowing in. Commands are never dropped or reordered. A held command simply waits with valid and its command word stable.

The comparison is not made on the full rank address. A 3-bit hash is taken from selected rank-address bits: the slot bit d, the master-rank bits m1 and m2, and the stack bits s0, s1 and s2. A selection mode picks which three bits form the hash. The refreshing rank is hashed the same way. Each queue path has its own enable. Configuration is copied into a shadow register only while no refresh is running. A small state machine tracks the refresh: in state OPEN no refresh has been seen yet, and the refreshing rank is taken live from its input. The transition OPEN to HOLD fires on a clock edge where refresh-active is high, and that edge latches the refreshing rank. HOLD stays while refresh-active is high. The transition HOLD to OPEN fires on the first edge where it is low. The intended settings are as follows. One slot with 1, 2 or 4 master ranks uses mode 000, 001 or 100. Two slots with 1, 2 or 4 master ranks use 010, 011 or 100. The enables should be left off in three cases: a single rank, more than eight ranks, and one slot holding four master ranks on a two-high stack.

Top module: `refresh_admit_filter`

## Requirements
- R1: Rank field encoding inside the command word, starting at bit RANK_LSB: bit 0 is s0, bit 1 is s1, bit 2 is s2, bit 3 is m1, bit 4 is m2 and bit 5 is d. The refresh rank input uses the same encoding. In mode 000 the hash is {s2,s1,s0}, so commands that differ only in d, m1 or m2 still match.
- R2: Mode 001 hashes m2,s2,s1. Mode 010 hashes d,s2,s1. Mode 011 hashes d,m2,s2. Mode 100 hashes d,m2,m1. A difference in a hashed bit prevents a match. A difference in an unhashed bit does not.
- R3: An enabled path whose command hash equals the refreshing rank's hash drives out_valid low and in_ready low, in the same cycle.
- R4: A path that is not blocking passes its inputs through: out_valid equals in_valid, in_ready equals out_ready, and out_cmd always equals in_cmd.
- R5: A path whose shadow enable is 0 never blocks, in any mode.
- R6: The strongly-ordered and non-strongly-ordered paths have separate enables. Enabling one path leaves the other transparent.
- R7: The reserved mode values 101, 110 and 111 never block.
- R8: Blocking happens only while refresh_active is high. A command held during the last refresh cycle passes in the first cycle where refresh_active is low.
- R9: The shadow configuration loads the configuration inputs on each clock edge where refresh_active is low. A change made during a refresh takes effect only after the refresh ends.
- R10: The refreshing rank is latched on the first clock edge of a refresh. Later changes to the refresh rank input during that refresh are ignored.
- R11: After reset both shadow enables are 0 and the state is OPEN, so nothing is blocked until a configuration has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_so_en | input | 1 | Blocking enable, strongly-ordered path |
| cfg_nso_en | input | 1 | Blocking enable, non-strongly-ordered path |
| cfg_sel | input | 3 | Hash bit selection mode |
| refresh_active | input | 1 | A rank refresh is in progress |
| refresh_rank | input | 6 | Rank under refresh (R1 encoding) |
| so_in_valid | input | 1 | Strongly-ordered command valid from source |
| so_in_cmd | input | CMD_W | Strongly-ordered command word |
| so_in_ready | output | 1 | Ready to strongly-ordered source |
| so_out_valid | output | 1 | Valid to strongly-ordered queue |
| so_out_cmd | output | CMD_W | Command to strongly-ordered queue |
| so_out_ready | input | 1 | Strongly-ordered queue ready |
| nso_in_valid | input | 1 | Non-strongly-ordered command valid |
| nso_in_cmd | input | CMD_W | Non-strongly-ordered command word |
| nso_in_ready | output | 1 | Ready to non-strongly-ordered source |
| nso_out_valid | output | 1 | Valid to non-strongly-ordered queue |
| nso_out_cmd | output | CMD_W | Command to non-strongly-ordered queue |
| nso_out_ready | input | 1 | Non-strongly-ordered queue ready |

## Verification
The bench pairs each mode with two commands. One differs from the refreshing rank only in unhashed bits and must be held; a wrong bit pick in the hash would let it through. The other differs in one hashed bit and must pass; a wrong bit pick would block it. The bench also changes the enables and the refresh rank input in the middle of a refresh. A design that loaded them at any time would stop blocking or start blocking a different rank part-way through. Other cases are the reserved modes, the enable that belongs to one path only, and the cycle in which refresh ends. These would expose blocking on a garbage hash, enables crossed between the paths, and a release that comes one cycle late.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int RANK_W = 6;
    localparam int HASH_W = 3;
    localparam int SEL_W  = 3;

    // rank field bit positions
    localparam int RB_S0 = 0;
    localparam int RB_S1 = 1;
    localparam int RB_S2 = 2;
    localparam int RB_M1 = 3;
    localparam int RB_M2 = 4;
    localparam int RB_D  = 5;

    localparam logic [SEL_W-1:0] SEL_STACK       = 3'b000;
    localparam logic [SEL_W-1:0] SEL_MASTER_STK  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_SLOT_STK    = 3'b010;
    localparam logic [SEL_W-1:0] SEL_SLOT_MS     = 3'b011;
    localparam logic [SEL_W-1:0] SEL_SLOT_MASTER = 3'b100;

    typedef struct packed {
        logic             en_so;
        logic             en_nso;
        logic [SEL_W-1:0] sel;
    } filt_cfg_t;

    typedef enum logic [0:0] {
        TRK_OPEN = 1'b0,
        TRK_HOLD = 1'b1
    } trk_state_e;

    // returns {usable, hash}; reserved selections are not usable
    function automatic logic [HASH_W:0] rank_hash(input logic [RANK_W-1:0] r,
                                                 input logic [SEL_W-1:0] sel);
        logic [HASH_W:0] res;
        case (sel)
            SEL_STACK:       res = {1'b1, r[RB_S2], r[RB_S1], r[RB_S0]};
            SEL_MASTER_STK:  res = {1'b1, r[RB_M2], r[RB_S2], r[RB_S1]};
            SEL_SLOT_STK:    res = {1'b1, r[RB_D],  r[RB_S2], r[RB_S1]};
            SEL_SLOT_MS:     res = {1'b1, r[RB_D],  r[RB_M2], r[RB_S2]};
            SEL_SLOT_MASTER: res = {1'b1, r[RB_D],  r[RB_M2], r[RB_M1]};
            default:         res = '0;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/rfb_refresh_tracker.sv
module rfb_refresh_tracker
    import rfb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  refresh_i,
    input  logic [RANK_W-1:0]     ref_rank_i,
    input  filt_cfg_t             cfg_i,
    output filt_cfg_t             cfg_q,
    output logic [HASH_W-1:0]     ref_hash_o,
    output logic                  ref_ok_o
);
    trk_state_e          state_q, state_d;
    logic [RANK_W-1:0]   ref_q;
    logic [RANK_W-1:0]   eff_rank;
    logic [HASH_W:0]     hres;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_OPEN: if (refresh_i)  state_d = TRK_HOLD;
            TRK_HOLD: if (!refresh_i) state_d = TRK_OPEN;
        endcase
    end

    // shadow configuration, frozen during refresh
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '{en_so: 1'b0, en_nso: 1'b0, sel: SEL_STACK};
        else if (!refresh_i) cfg_q <= cfg_i;
    end

    // refreshing rank latched on the opening edge of a refresh
    always_ff @(posedge clk) begin
        if (!rst_n)                                ref_q <= '0;
        else if (state_q == TRK_OPEN && refresh_i) ref_q <= ref_rank_i;
    end

    always_comb begin
        unique case (state_q)
            TRK_OPEN: eff_rank = ref_rank_i;
            TRK_HOLD: eff_rank = ref_q;
        endcase
        hres       = rank_hash(eff_rank, cfg_q.sel);
        ref_ok_o   = hres[HASH_W];
        ref_hash_o = hres[HASH_W-1:0];
    end

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> $stable(cfg_q));
    a_r10_rank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_HOLD && refresh_i) |=> $stable(ref_q));
    a_r8_hold_follows_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_HOLD) |-> $past(refresh_i));
endmodule

// File: rtl/rfb_admit_gate.sv
module rfb_admit_gate
    import rfb_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int RANK_LSB = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  refresh_on,
    input  logic [HASH_W-1:0]     ref_hash,
    input  logic                  ref_ok,
    input  logic                  in_valid,
    input  logic [CMD_W-1:0]      in_cmd,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [CMD_W-1:0]      out_cmd,
    input  logic                  out_ready
);
    logic [HASH_W:0] cres;
    logic            hit;
    logic            stall;

    always_comb begin
        cres      = rank_hash(in_cmd[RANK_LSB +: RANK_W], sel);
        hit       = cres[HASH_W] && ref_ok && (cres[HASH_W-1:0] == ref_hash);
        stall     = refresh_on && en && hit;
        out_valid = in_valid && !stall;
        in_ready  = out_ready && !stall;
        out_cmd   = in_cmd;
    end

    a_r8_idle_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_on |-> (out_valid == in_valid && in_ready == out_ready));
    a_r5_disabled_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (out_valid == in_valid && in_ready == out_ready));
    a_r7_reserved_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > SEL_SLOT_MASTER) |-> (out_valid == in_valid && in_ready == out_ready));
    a_r3_hold_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |-> !in_ready);
    a_r4_cmd_through: assert property (@(posedge clk) disable iff (!rst_n)
        out_cmd == in_cmd);
endmodule

// File: rtl/refresh_admit_filter.sv
module refresh_admit_filter
    import rfb_pkg::*;
#(
    parameter int CMD_W    = 16,
    parameter int RANK_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_so_en,
    input  logic             cfg_nso_en,
    input  logic [2:0]       cfg_sel,
    input  logic             refresh_active,
    input  logic [5:0]       refresh_rank,
    input  logic             so_in_valid,
    input  logic [CMD_W-1:0] so_in_cmd,
    output logic             so_in_ready,
    output logic             so_out_valid,
    output logic [CMD_W-1:0] so_out_cmd,
    input  logic             so_out_ready,
    input  logic             nso_in_valid,
    input  logic [CMD_W-1:0] nso_in_cmd,
    output logic             nso_in_ready,
    output logic             nso_out_valid,
    output logic [CMD_W-1:0] nso_out_cmd,
    input  logic             nso_out_ready
);
    localparam int NPATH = 2;

    filt_cfg_t                    cfg_in, cfg_q;
    logic [HASH_W-1:0]            ref_hash;
    logic                         ref_ok;
    logic [NPATH-1:0]             p_en, p_iv, p_ir, p_ov, p_or;
    logic [NPATH-1:0][CMD_W-1:0]  p_ic, p_oc;

    always_comb begin
        cfg_in = '{en_so: cfg_so_en, en_nso: cfg_nso_en, sel: cfg_sel};
        p_en   = {cfg_q.en_nso, cfg_q.en_so};
        p_iv   = {nso_in_valid, so_in_valid};
        p_ic   = {nso_in_cmd, so_in_cmd};
        p_or   = {nso_out_ready, so_out_ready};
        so_in_ready   = p_ir[0];
        so_out_valid  = p_ov[0];
        so_out_cmd    = p_oc[0];
        nso_in_ready  = p_ir[1];
        nso_out_valid = p_ov[1];
        nso_out_cmd   = p_oc[1];
    end

    rfb_refresh_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .refresh_i  (refresh_active),
        .ref_rank_i (refresh_rank),
        .cfg_i      (cfg_in),
        .cfg_q      (cfg_q),
        .ref_hash_o (ref_hash),
        .ref_ok_o   (ref_ok)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        rfb_admit_gate #(.CMD_W(CMD_W), .RANK_LSB(RANK_LSB)) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (p_en[g]),
            .sel        (cfg_q.sel),
            .refresh_on (refresh_active),
            .ref_hash   (ref_hash),
            .ref_ok     (ref_ok),
            .in_valid   (p_iv[g]),
            .in_cmd     (p_ic[g]),
            .in_ready   (p_ir[g]),
            .out_valid  (p_ov[g]),
            .out_cmd    (p_oc[g]),
            .out_ready  (p_or[g])
        );
    end

    initial begin
        if (RANK_LSB + RANK_W > CMD_W) $error("rank field exceeds command width");
    end
endmodule

// File: tb/sim_refresh_admit_filter.sv
module sim_refresh_admit_filter;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic cfg_so_en = 0, cfg_nso_en = 0;
    logic [2:0] cfg_sel = 0;
    logic refresh_active = 0;
    logic [5:0] refresh_rank = 0;
    logic so_in_valid = 0, so_out_ready = 0, nso_in_valid = 0, nso_out_ready = 0;
    logic [CW-1:0] so_in_cmd = 0, nso_in_cmd = 0;
    logic so_in_ready, so_out_valid, nso_in_ready, nso_out_valid;
    logic [CW-1:0] so_out_cmd, nso_out_cmd;

    refresh_admit_filter #(.CMD_W(CW), .RANK_LSB(4)) u0 (.*);

    typedef struct {
        logic sov, sordy, nsov, nsordy;
        logic [CW-1:0] soc, nsoc;
        string tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0;
    bit done = 0;

    // wanted configuration, applied by the driver
    logic w_so = 0, w_nso = 0;
    logic [2:0] w_sel = 0;
    // bench model state
    logic m_so = 0, m_nso = 0, m_hold = 0;
    logic [2:0] m_sel = 0;
    logic [5:0] m_ref = 0;

    function automatic logic [5:0] rk(logic d, logic [1:0] m, logic [2:0] s);
        return {d, m, s};
    endfunction

    function automatic logic [CW-1:0] mk(logic [5:0] r);
        return {6'h15, r, 4'hA};
    endfunction

    // R1/R2 hash model: returns {ok, h}
    function automatic logic [3:0] bh(logic [5:0] r, logic [2:0] md);
        logic d, m1, m2, s0, s1, s2;
        {d, m2, m1, s2, s1, s0} = r;
        if (md == 3'd0) return {1'b1, s2, s1, s0};
        if (md == 3'd1) return {1'b1, m2, s2, s1};
        if (md == 3'd2) return {1'b1, d, s2, s1};
        if (md == 3'd3) return {1'b1, d, m2, s2};
        if (md == 3'd4) return {1'b1, d, m2, m1};
        return 4'b0000;
    endfunction

    task automatic step(input logic rf, input logic [5:0] rr,
                        input logic sv, input logic [5:0] sr, input logic srdy,
                        input logic nv, input logic [5:0] nr, input logic nrdy,
                        input string tag);
        exp_t e;
        logic [5:0] eff;
        logic [3:0] hr, hs, hn;
        logic bs, bn;
        @(negedge clk);
        cfg_so_en = w_so; cfg_nso_en = w_nso; cfg_sel = w_sel;
        refresh_active = rf; refresh_rank = rr;
        so_in_valid = sv; so_in_cmd = mk(sr); so_out_ready = srdy;
        nso_in_valid = nv; nso_in_cmd = mk(nr); nso_out_ready = nrdy;
        eff = m_hold ? m_ref : rr;
        hr = bh(eff, m_sel); hs = bh(sr, m_sel); hn = bh(nr, m_sel);
        bs = rf && m_so  && hr[3] && hs[3] && (hr[2:0] == hs[2:0]);
        bn = rf && m_nso && hr[3] && hn[3] && (hr[2:0] == hn[2:0]);
        e.sov = sv && !bs; e.sordy = srdy && !bs;
        e.nsov = nv && !bn; e.nsordy = nrdy && !bn;
        e.soc = mk(sr); e.nsoc = mk(nr); e.tag = tag;
        sb.push_back(e);
        if (!rf) begin
            m_so = w_so; m_nso = w_nso; m_sel = w_sel; m_hold = 0;
        end else if (!m_hold) begin
            m_ref = rr; m_hold = 1;
        end
    endtask

    task automatic cmp(input logic a, input logic x, input string tag, input string what);
        checks++;
        if (a !== x) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, a, x);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(so_out_valid, e.sov, e.tag, "so_out_valid");
                cmp(so_in_ready, e.sordy, e.tag, "so_in_ready");
                cmp(nso_out_valid, e.nsov, e.tag, "nso_out_valid");
                cmp(nso_in_ready, e.nsordy, e.tag, "nso_in_ready");
                checks++;
                if (so_out_cmd !== e.soc || nso_out_cmd !== e.nsoc) begin
                    fails++;
                    $display("FAIL %s R4 cmd actual=%h/%h expected=%h/%h",
                             e.tag, so_out_cmd, nso_out_cmd, e.soc, e.nsoc);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] rr_a [4];
        logic [5:0] hit_a [4];
        logic [5:0] miss_a [4];
        rr_a   = '{rk(0,2'b10,3'b110), rk(1,2'b00,3'b010), rk(1,2'b10,3'b100), rk(0,2'b01,3'b000)};
        hit_a  = '{rk(1,2'b11,3'b111), rk(1,2'b11,3'b011), rk(1,2'b11,3'b111), rk(0,2'b01,3'b111)};
        miss_a = '{rk(0,2'b00,3'b110), rk(0,2'b00,3'b010), rk(1,2'b10,3'b000), rk(0,2'b11,3'b000)};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R11: enables off after reset; refresh keeps the shadow from loading (R9)
        w_so = 1; w_nso = 0; w_sel = 3'd0;
        step(1, rk(0,0,3), 1, rk(0,0,3), 1, 1, rk(0,0,3), 1, "R11 reset no block");
        step(1, rk(0,0,3), 1, rk(0,0,3), 1, 1, rk(0,0,3), 1, "R9 cfg not loaded in refresh");
        step(0, rk(0,0,3), 1, rk(0,0,3), 1, 1, rk(0,0,3), 1, "R8 idle passes");

        // R1, R6: mode 000, only strongly-ordered path enabled
        step(1, rk(0,0,3), 1, rk(0,2,3), 1, 1, rk(0,0,3), 1, "R1 R6 stack hash match");
        step(1, rk(0,0,5), 1, rk(0,0,3), 1, 1, rk(0,0,3), 1, "R10 rank change ignored");
        step(1, rk(0,0,5), 1, rk(0,0,5), 1, 1, rk(0,0,5), 1, "R10 new rank not blocked");
        step(0, rk(0,0,5), 1, rk(0,0,3), 1, 1, rk(0,0,3), 1, "R8 release on refresh low");

        // R2, R3: remaining modes, both paths enabled
        w_nso = 1;
        for (int i = 0; i < 4; i++) begin
            w_sel = 3'(i + 1);
            step(0, rr_a[i], 0, rr_a[i], 1, 0, rr_a[i], 1, "R2 load mode");
            step(1, rr_a[i], 1, hit_a[i], 1, 1, hit_a[i], 1, "R2 R3 unhashed bits differ");
            step(1, rr_a[i], 1, miss_a[i], 1, 1, hit_a[i], 0, "R2 hashed bit differs");
            step(0, rr_a[i], 1, hit_a[i], 1, 1, hit_a[i], 1, "R8 mode release");
        end

        // R7: reserved modes
        for (int i = 5; i < 8; i++) begin
            w_sel = 3'(i);
            step(0, rk(1,3,7), 0, rk(1,3,7), 1, 0, rk(1,3,7), 1, "R7 load reserved");
            step(1, rk(1,3,7), 1, rk(1,3,7), 1, 1, rk(1,3,7), 1, "R7 reserved no block");
        end

        // R5: both disabled
        w_so = 0; w_nso = 0; w_sel = 3'd0;
        step(0, rk(0,1,2), 0, rk(0,1,2), 1, 0, rk(0,1,2), 1, "R5 load disabled");
        step(1, rk(0,1,2), 1, rk(0,1,2), 1, 1, rk(0,1,2), 1, "R5 disabled no block");

        // R9: enable dropped in the middle of a refresh
        w_so = 1; w_nso = 1; w_sel = 3'd0;
        step(0, rk(0,1,2), 0, rk(0,1,2), 1, 0, rk(0,1,2), 1, "R9 load enabled");
        step(1, rk(0,1,2), 1, rk(0,1,2), 1, 1, rk(0,1,2), 1, "R3 blocked");
        w_so = 0; w_nso = 0;
        step(1, rk(0,1,2), 1, rk(0,1,2), 1, 1, rk(0,1,2), 1, "R9 still blocked");
        step(0, rk(0,1,2), 1, rk(0,1,2), 1, 1, rk(0,1,2), 1, "R8 released");
        step(1, rk(0,1,2), 1, rk(0,1,2), 1, 1, rk(0,1,2), 1, "R9 disable now active");

        // R4: queue backpressure and idle source pass through
        w_so = 1; w_nso = 1;
        step(0, rk(0,0,0), 1, rk(0,0,1), 0, 0, rk(0,0,1), 1, "R4 backpressure");
        step(1, rk(0,0,0), 0, rk(0,0,1), 0, 1, rk(0,0,6), 0, "R4 unblocked in refresh");
        step(0, rk(0,0,0), 0, rk(0,0,1), 1, 0, rk(0,0,1), 1, "R4 idle");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule